// File: doc/BRIEF.md
# ADC Oversampling Accumulator and Decimator

This block sits behind an analog-to-digital converter and raises the effective resolution of its 12-bit results. It adds up a power-of-two number of consecutive conversion results, then divides the total by a programmable power of two with round-to-nearest. The low 16 bits of that value are placed in an output register, together with a one-cycle end-of-conversion pulse. Only one result is produced for each group of samples, so the output rate is the input rate divided by the oversampling ratio.

A group of samples, called a burst here, begins on a start pulse. In single mode the block goes idle when the burst ends. In continuous mode the next burst begins as soon as the previous one ends. The ratio, the shift and the mode bit are captured when each burst begins. Dropping the enable or pulsing abort throws away any partial sum.

With a ratio of 64, a shift of 2 and a full-scale input, the output reaches 65520. With 60 clocks per conversion (12.5 conversion plus 47.5 sampling cycles) and a ratio of 64, one result appears every 3840 clocks, which is 60 µs at 64 MHz.

Top module: `adc_os_decim`

## Requirements
- R1: After reset, res_o is 0, eoc_o is 0 and busy_o is 0.
- R2: After a start with enable_i high, the block adds exactly 2^L samples, where L is the clamped osr_l2_i. Only cycles with smp_valid_i high count as samples, and no result appears before the last of them.
- R3: The result is (sum + 2^(S-1)) >> S for S > 0, and the plain sum for S = 0, where S is the clamped shift_i.
- R4: res_o carries only the low 16 bits of the shifted value. A ratio of 256, a shift of 0 and a full-scale input give 65280.
- R5: osr_l2_i = 0 is treated as 1 (ratio 2). osr_l2_i above 8 is treated as 8 (ratio 256). shift_i above 8 is treated as 8.
- R6: eoc_o is high for exactly one cycle, on the clock edge that accepts the last sample of a burst, and res_o updates on that same edge. Between results, res_o holds its value.
- R7: In single mode, busy_o falls when the burst ends. Samples that arrive while idle change neither res_o nor eoc_o.
- R8: In continuous mode, a new burst begins on the edge that completes the previous one. It captures osr_l2_i, shift_i and cont_i anew.
- R9: Changes to osr_l2_i, shift_i or cont_i during a burst do not affect that burst.
- R10: abort_i high, or enable_i low, clears the partial sum and the count and makes the block idle. The partial burst never produces a result.
- R11: A start pulse during a burst is ignored. The burst keeps its count and its configuration.
- R12: With one sample every 60 cycles, a ratio of 64 and continuous mode, consecutive eoc_o pulses are 3840 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Block enable; low clears any burst in progress |
| abort_i | input | 1 | Discards the burst in progress |
| start_i | input | 1 | Starts a burst when the block is idle |
| cont_i | input | 1 | Continuous mode, captured at burst start |
| osr_l2_i | input | 4 | log2 of the oversampling ratio, captured at burst start |
| shift_i | input | 4 | Right shift applied to the sum, captured at burst start |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 12 | Conversion result |
| res_o | output | 16 | Rounded, shifted and truncated result |
| eoc_o | output | 1 | One-cycle pulse marking a new result |
| busy_o | output | 1 | A burst is in progress |

## Verification
A result is due on the clock edge that accepts the last sample of a burst, so eoc_o and res_o are visible one cycle after that sample is driven. The bench drives every input on the falling edge and reads the outputs on the next falling edge. It therefore checks each result exactly one cycle after the final sample, and checks eoc_o low again one cycle later. Start and abort take effect at the next edge, so busy_o is checked one falling edge after the pulse. Pacing is checked by counting rising edges between two observed pulses.

// File: rtl/adc_os_pkg.sv
package adc_os_pkg;
  localparam int unsigned SMP_W        = 12;
  localparam int unsigned OUT_W        = 16;
  localparam int unsigned MAX_OSR_LOG2 = 8;
  localparam int unsigned MAX_SHIFT    = 8;
  localparam int unsigned ACC_W        = SMP_W + MAX_OSR_LOG2;
  localparam int unsigned CFG_W        = 4;

  typedef struct packed {
    logic [CFG_W-1:0] osr_l2;
    logic [CFG_W-1:0] shift;
    logic             cont;
  } os_cfg_t;
endpackage

// File: rtl/os_ctrl.sv
module os_ctrl
  import adc_os_pkg::*;
#(
  parameter int unsigned MAX_L2 = MAX_OSR_LOG2,
  parameter int unsigned MAX_SH = MAX_SHIFT,
  localparam int unsigned CNT_W = MAX_L2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             abort_i,
  input  logic             start_i,
  input  os_cfg_t          cfg_i,
  input  logic             smp_valid_i,
  output logic             busy_o,
  output logic             add_o,
  output logic             last_o,
  output logic             clr_o,
  output logic [CFG_W-1:0] shift_o
);
  function automatic logic [CFG_W-1:0] clamp_l2(input logic [CFG_W-1:0] v);
    if (v == '0) return CFG_W'(1);
    if (v > CFG_W'(MAX_L2)) return CFG_W'(MAX_L2);
    return v;
  endfunction

  function automatic logic [CFG_W-1:0] clamp_sh(input logic [CFG_W-1:0] v);
    if (v > CFG_W'(MAX_SH)) return CFG_W'(MAX_SH);
    return v;
  endfunction

  os_cfg_t          cfg_q, cfg_eff;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q, cnt_top;
  logic             kill;

  assign cfg_eff = '{osr_l2: clamp_l2(cfg_i.osr_l2),
                     shift:  clamp_sh(cfg_i.shift),
                     cont:   cfg_i.cont};
  assign kill    = abort_i | ~enable_i;
  assign cnt_top = {CNT_W{1'b1}} >> (CFG_W'(MAX_L2) - cfg_q.osr_l2);
  assign add_o   = busy_q & smp_valid_i & ~kill;
  assign last_o  = add_o & (cnt_q == cnt_top);
  assign clr_o   = kill | (~busy_q & start_i);
  assign busy_o  = busy_q;
  assign shift_o = cfg_q.shift;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      cfg_q  <= '{osr_l2: CFG_W'(1), shift: '0, cont: 1'b0};
    end else if (kill) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q && start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      cfg_q  <= cfg_eff;
    end else if (add_o) begin
      if (last_o) begin
        cnt_q  <= '0;
        busy_q <= cfg_q.cont;
        if (cfg_q.cont) cfg_q <= cfg_eff;  // auto re-trigger captures fresh config
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q <= cnt_top);  // R2
  AST_KILL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill |=> (!busy_q && cnt_q == '0));  // R10
  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o && !kill) |=> $stable(cfg_q));  // R9
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i && !add_o && !kill) |=> $stable(cnt_q));  // R11
endmodule

// File: rtl/os_accum.sv
module os_accum
  import adc_os_pkg::*;
#(
  parameter int unsigned IN_W  = SMP_W,
  parameter int unsigned SUM_W = ACC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic             last_i,
  input  logic [IN_W-1:0]  data_i,
  output logic [SUM_W-1:0] sum_o
);
  logic [SUM_W-1:0] acc_q;
  logic [SUM_W:0]   wide;

  assign sum_o = acc_q + SUM_W'(data_i);
  assign wide  = {1'b0, acc_q} + (SUM_W+1)'(data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (add_i)  acc_q <= last_i ? '0 : sum_o;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_i |-> !wide[SUM_W]);  // R2
endmodule

// File: rtl/os_round_shift.sv
module os_round_shift
  import adc_os_pkg::*;
#(
  parameter int unsigned SUM_W = ACC_W,
  parameter int unsigned RES_W = OUT_W,
  parameter int unsigned MAX_SH = MAX_SHIFT,
  localparam int unsigned RW = SUM_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [SUM_W-1:0] sum_i,
  input  logic [CFG_W-1:0] shift_i,
  output logic [RES_W-1:0] res_o,
  output logic             eoc_o
);
  logic [RW-1:0] cand [0:MAX_SH];
  logic [RW-1:0] sel;

  assign cand[0] = {1'b0, sum_i};
  for (genvar g = 1; g <= MAX_SH; g++) begin : g_shift
    assign cand[g] = ({1'b0, sum_i} + (RW'(1) << (g - 1))) >> g;
  end

  always_comb begin
    sel = cand[0];
    for (int k = 1; k <= MAX_SH; k++)
      if (shift_i == CFG_W'(k)) sel = cand[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      eoc_o <= 1'b0;
    end else begin
      eoc_o <= load_i;
      if (load_i) res_o <= sel[RES_W-1:0];  // keep low bits only
    end
  end

  AST_ROUND_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (sel >= ({1'b0, sum_i} >> shift_i)) &&
               (sel <= (({1'b0, sum_i} >> shift_i) + RW'(1))));  // R3
  AST_EOC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !eoc_o);  // R6
endmodule

// File: rtl/adc_os_decim.sv
module adc_os_decim
  import adc_os_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic             cont_i,
  input  logic [CFG_W-1:0] osr_l2_i,
  input  logic [CFG_W-1:0] shift_i,
  input  logic             smp_valid_i,
  input  logic [SMP_W-1:0] smp_data_i,
  output logic [OUT_W-1:0] res_o,
  output logic             eoc_o,
  output logic             busy_o
);
  os_cfg_t          cfg;
  logic             add, last, clr;
  logic [CFG_W-1:0] shift_q;
  logic [ACC_W-1:0] sum;

  assign cfg = '{osr_l2: osr_l2_i, shift: shift_i, cont: cont_i};

  os_ctrl #(.MAX_L2(MAX_OSR_LOG2), .MAX_SH(MAX_SHIFT)) u_ctrl (
    .clk_i, .rst_ni, .enable_i, .abort_i, .start_i,
    .cfg_i(cfg), .smp_valid_i, .busy_o,
    .add_o(add), .last_o(last), .clr_o(clr), .shift_o(shift_q)
  );

  os_accum #(.IN_W(SMP_W), .SUM_W(ACC_W)) u_accum (
    .clk_i, .rst_ni, .clr_i(clr), .add_i(add), .last_i(last),
    .data_i(smp_data_i), .sum_o(sum)
  );

  os_round_shift #(.SUM_W(ACC_W), .RES_W(OUT_W), .MAX_SH(MAX_SHIFT)) u_rs (
    .clk_i, .rst_ni, .load_i(last), .sum_i(sum), .shift_i(shift_q),
    .res_o, .eoc_o
  );

  AST_EOC_AFTER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> $past(busy_o));  // R7
endmodule

// File: tb/adc_os_decim_bench.sv
`timescale 1ns/1ps
module adc_os_decim_bench;
  logic        clk_i = 0, rst_ni = 0, enable_i = 0, abort_i = 0, start_i = 0, cont_i = 0;
  logic [3:0]  osr_l2_i = 0, shift_i = 0;
  logic        smp_valid_i = 0;
  logic [11:0] smp_data_i = 0;
  logic [15:0] res_o;
  logic        eoc_o, busy_o;

  int n_tests = 0, n_fail = 0;
  longint cyc = 0, last_eoc = 0;

  adc_os_decim u_adc_os_decim (.*);

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk_i);
  endtask

  function automatic longint exp_res(input longint sum, input int sh);
    longint r;
    r = (sh > 0) ? ((sum + (longint'(1) << (sh - 1))) >> sh) : sum;
    return r & 16'hFFFF;
  endfunction

  task automatic start_cfg(input int l2, input int sh, input bit cont);
    osr_l2_i = 4'(l2); shift_i = 4'(sh); cont_i = cont;
    start_i = 1; step; start_i = 0;
  endtask

  // mode 0: random data; otherwise first sample va, the rest vb
  task automatic burst(input int n, input int sh, input int mode, input int va, input int vb,
                       input int fixgap, input string req);
    longint sum = 0;
    bit early = 0;
    int d, g;
    for (int i = 0; i < n; i++) begin
      d = (mode == 0) ? int'($urandom_range(4095)) : ((i == 0) ? va : vb);
      sum += d;
      smp_valid_i = 1; smp_data_i = 12'(d);
      step;
      smp_valid_i = 0;
      if (i < n - 1) begin
        if (eoc_o) early = 1;
        g = (fixgap >= 0) ? fixgap : int'($urandom_range(3));
        for (int k = 0; k < g; k++) begin step; if (eoc_o) early = 1; end
      end
    end
    chk(!early, {req, " no early result"}, early, 0);
    chk(eoc_o == 1'b1, {req, " eoc"}, eoc_o, 1);
    chk(longint'(res_o) == exp_res(sum, sh), {req, " result"}, res_o, exp_res(sum, sh));
    last_eoc = cyc;
    g = (fixgap >= 1) ? fixgap : 1 + int'($urandom_range(2));
    step;
    chk(eoc_o == 1'b0, {req, " R6 pulse width"}, eoc_o, 0);
    for (int k = 1; k < g; k++) step;
  endtask

  task automatic loose_samples(input int n, input string req);
    logic [15:0] held = res_o;
    bit seen = 0;
    for (int i = 0; i < n; i++) begin
      smp_valid_i = 1; smp_data_i = 12'($urandom_range(4095));
      step;
      if (eoc_o) seen = 1;
    end
    smp_valid_i = 0;
    step;
    if (eoc_o) seen = 1;
    chk(!seen, {req, " no eoc"}, seen, 0);
    chk(res_o == held, {req, " res held"}, res_o, held);
  endtask

  initial begin
    longint t0;
    void'($urandom(32'h5eed_0a1c));
    repeat (3) step;
    // R1
    chk(res_o == 0, "R1 res", res_o, 0);
    chk(eoc_o == 0, "R1 eoc", eoc_o, 0);
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    rst_ni = 1; enable_i = 1; step;

    // R2 R3: ratio 64, shift 2, full scale -> 65520
    start_cfg(6, 2, 0);
    chk(busy_o == 1, "R2 busy after start", busy_o, 1);
    burst(64, 2, 1, 4095, 4095, 1, "R2 R3 full scale");
    chk(res_o == 16'd65520, "R3 full scale value", res_o, 65520);

    // R3 rounding boundaries at ratio 2
    start_cfg(1, 2, 0); burst(2, 2, 1, 1, 0, 0, "R3 round down");
    start_cfg(1, 2, 0); burst(2, 2, 1, 2, 0, 0, "R3 round up");
    start_cfg(1, 1, 0); burst(2, 1, 1, 4095, 4094, 2, "R3 half odd");

    // R4: truncation
    start_cfg(8, 0, 0); burst(256, 0, 1, 4095, 4095, 0, "R4 truncate");
    chk(res_o == 16'd65280, "R4 value", res_o, 65280);

    // R5: clamps
    start_cfg(0, 15, 0); burst(2, 8, 1, 4095, 4095, 1, "R5 low ratio, high shift");
    start_cfg(12, 3, 0); burst(256, 3, 0, 0, 0, 0, "R5 high ratio");

    // R7: idle samples ignored
    chk(busy_o == 0, "R7 idle after single", busy_o, 0);
    loose_samples(6, "R7 idle");

    // Random bursts: R2 R3 R4
    for (int t = 0; t < 25; t++) begin
      int l2 = 1 + int'($urandom_range(5));
      int sh = int'($urandom_range(8));
      int md = int'($urandom_range(1)) * 3;
      start_cfg(l2, sh, 0);
      burst(1 << l2, sh, md, 4095, 4095, -1, "R2 R3 R4 random");
    end

    // R11: start during burst ignored
    start_cfg(2, 0, 0);
    fork
      burst(4, 0, 0, 0, 0, 1, "R11 start ignored");
      begin step; step; step; osr_l2_i = 4; shift_i = 3; start_i = 1; step; start_i = 0; end
    join

    // R8 R9: continuous, config change mid-burst
    start_cfg(2, 1, 1);
    fork
      burst(4, 1, 0, 0, 0, 2, "R9 old config kept");
      begin step; osr_l2_i = 1; shift_i = 0; end
    join
    chk(busy_o == 1, "R8 auto restart", busy_o, 1);
    cont_i = 0;
    burst(2, 0, 0, 0, 0, 1, "R8 new config");
    burst(2, 0, 0, 0, 0, 1, "R8 cont captured off");
    chk(busy_o == 0, "R8 stops after cont cleared", busy_o, 0);

    // R10: abort
    start_cfg(3, 0, 0);
    for (int i = 0; i < 3; i++) begin smp_valid_i = 1; smp_data_i = 12'd4000; step; end
    smp_valid_i = 0; abort_i = 1; step; abort_i = 0;
    chk(busy_o == 0, "R10 abort idle", busy_o, 0);
    loose_samples(10, "R10 abort");
    start_cfg(3, 0, 0); burst(8, 0, 1, 7, 1, 0, "R10 fresh sum after abort");

    // R10: enable low
    start_cfg(3, 1, 0);
    for (int i = 0; i < 5; i++) begin smp_valid_i = 1; smp_data_i = 12'd3000; step; end
    smp_valid_i = 0; enable_i = 0; step;
    chk(busy_o == 0, "R10 disable idle", busy_o, 0);
    start_i = 1; step; start_i = 0;
    chk(busy_o == 0, "R10 start ignored while disabled", busy_o, 0);
    enable_i = 1;
    loose_samples(8, "R10 disable");
    start_cfg(3, 1, 0); burst(8, 1, 1, 5, 2, 0, "R10 fresh sum after disable");

    // R12: pacing, 60 cycles per sample
    start_cfg(6, 2, 1);
    burst(64, 2, 0, 0, 0, 59, "R12 pacing first");
    t0 = last_eoc;
    cont_i = 0;
    burst(64, 2, 0, 0, 0, 59, "R12 pacing second");
    chk(last_eoc - t0 == 3840, "R12 period", last_eoc - t0, 3840);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule